// File: doc/BRIEF.md
# Host/Guest Mailbox Doorbell Bank

This block holds one 32-bit mailbox word per guest function and shares it between a single host port and a set of guest ports. The low half of a word carries messages from the host to that guest; the high half carries messages from the guest to the host. Each half has a doorbell bit at its bottom. A set host-to-guest doorbell raises that guest's interrupt. A set guest-to-host doorbell marks the guest in a pending vector and raises the host interrupt. The receiving side acknowledges a message by writing its doorbell back to zero.

The host port can read and write any word. Each guest port reaches only the word at its own index. Writes carry byte enables, so one side can update its half without touching the other half. Decoded views of each half report whether a valid system message is present, along with its type and data fields. A parameter selects a second layout. In that layout, each guest has two separate 32-bit words, one per direction, with the doorbell at bit 0 of each.

Top module: `pfvf_mailbox`

## Requirements
- R1: While reset is high, and after it is released, every word holds zero, all guest interrupts and the host interrupt are low, and the pending vector is zero.
- R2: A host write that sets bit 0 of guest i's word raises vf_irq[i] from the next cycle on.
- R3: A guest write to its own word that sets bit 16 raises pf_pending[i] and pf_irq from the next cycle on.
- R4: Writing a doorbell bit back to 0 (bit 0 by the guest, bit 16 by the host) drops the matching interrupt or pending bit on the next cycle.
- R5: A half is a valid system message only when its doorbell (bit 0 of the half) and its origin flag (bit 1 of the half) are both 1. With origin 0 the message is legacy and the sys flag stays 0. The type is bits 5:2 of the half, and the data is bits 15:6.
- R6: A guest write whose address differs from its own index changes nothing. While the address differs, vf_deny[i] is 1 and vf_rdata reads zero.
- R7: The host reads any word combinationally on pf_rdata, and a guest reads its own word on its vf_rdata.
- R8: Only bytes whose enable bit is 1 are written. The other bytes keep their value.
- R9: When the host and a guest write the same byte of the same word in one cycle, the host data is stored.
- R10: pf_src_idx gives the lowest-numbered guest with a pending bit.
- R11: With SPLIT=1, each guest has separate host-to-guest and guest-to-host words, chosen by the dir input (0 host-to-guest, 1 guest-to-host). The doorbell is bit 0 and the origin flag is bit 1 of each word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pf_wr | input | 1 | Host write strobe |
| pf_addr | input | IDX_W | Host word index |
| pf_be | input | 4 | Host byte enables |
| pf_wdata | input | 32 | Host write data |
| pf_dir | input | 1 | Host word select in split layout |
| pf_rdata | output | 32 | Host read data for pf_addr |
| pf_irq | output | 1 | Host interrupt |
| pf_pending | output | NUM_VF | Guests whose guest-to-host doorbell is set |
| pf_src_idx | output | IDX_W | Lowest pending guest |
| pf_msg_sys | output | 1 | Guest-to-host half at pf_addr is a valid system message |
| pf_msg_type | output | 4 | Its type field |
| pf_msg_data | output | 10 | Its data field |
| vf_wr | input | NUM_VF | Guest write strobes |
| vf_addr | input | NUM_VF*IDX_W | Guest word indices |
| vf_be | input | NUM_VF*4 | Guest byte enables |
| vf_wdata | input | NUM_VF*32 | Guest write data |
| vf_dir | input | NUM_VF | Guest word select in split layout |
| vf_rdata | output | NUM_VF*32 | Guest read data |
| vf_deny | output | NUM_VF | Guest address does not match its own index |
| vf_irq | output | NUM_VF | Guest interrupts |
| vf_msg_sys | output | NUM_VF | Host-to-guest half is a valid system message |
| vf_msg_type | output | NUM_VF*4 | Its type field |
| vf_msg_data | output | NUM_VF*10 | Its data field |

## Verification
Some properties are checked on every cycle. A host doorbell write is followed by the guest interrupt, and a guest doorbell write is followed by the pending bit. A host clear drops the pending bit, and a denied guest write leaves the interrupts unchanged. A decoded sys flag never appears without its doorbell, and the reported source always points at a pending guest. Other behaviours only the bench's scenarios can show: the exact stored word after partial byte enables, host priority in a same-byte collision, field extraction for chosen type and data values, the legacy-origin case, and the split layout keeping its two words apart.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int WORD_W  = 32;
    localparam int BYTES   = WORD_W / 8;
    localparam int HALF_W  = WORD_W / 2;
    localparam int KIND_W  = 4;
    localparam int DATA_W  = HALF_W - KIND_W - 2;

    // One directional half of a mailbox word, doorbell in the lowest bit
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [KIND_W-1:0] kind;
        logic              origin;
        logic              bell;
    } half_t;

    typedef struct packed {
        logic              sys;
        logic [KIND_W-1:0] kind;
        logic [DATA_W-1:0] data;
    } msg_t;

    function automatic msg_t decode_half(input logic [HALF_W-1:0] raw);
        half_t h;
        msg_t  m;
        h      = half_t'(raw);
        m.sys  = h.bell & h.origin;
        m.kind = h.kind;
        m.data = h.data;
        return m;
    endfunction

    // Byte-lane merge: host lanes override guest lanes
    function automatic logic [WORD_W-1:0] merge_word(
        input logic [WORD_W-1:0] old_w,
        input logic [BYTES-1:0]  host_en,
        input logic [WORD_W-1:0] host_d,
        input logic [BYTES-1:0]  guest_en,
        input logic [WORD_W-1:0] guest_d
    );
        logic [WORD_W-1:0] r;
        r = old_w;
        for (int b = 0; b < BYTES; b++) begin
            if (host_en[b])
                r[b*8 +: 8] = host_d[b*8 +: 8];
            else if (guest_en[b])
                r[b*8 +: 8] = guest_d[b*8 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/mbx_slot.sv
module mbx_slot
    import mbx_pkg::*;
#(
    parameter bit SPLIT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pf_we,
    input  logic [BYTES-1:0]  pf_be,
    input  logic [WORD_W-1:0] pf_wdata,
    input  logic              pf_dir,
    input  logic              vf_we,
    input  logic [BYTES-1:0]  vf_be,
    input  logic [WORD_W-1:0] vf_wdata,
    input  logic              vf_dir,
    output logic [WORD_W-1:0] pf_view,
    output logic [WORD_W-1:0] vf_view,
    output logic [HALF_W-1:0] p2v_half,
    output logic [HALF_W-1:0] v2p_half
);

    generate
        if (SPLIT) begin : g_split
            logic [WORD_W-1:0] to_vf_q;
            logic [WORD_W-1:0] to_pf_q;
            logic [BYTES-1:0]  pf_en_tv, pf_en_tp, vf_en_tv, vf_en_tp;
            logic [HALF_W-1:0] upper_unused;

            assign pf_en_tv = (pf_we && !pf_dir) ? pf_be : '0;
            assign pf_en_tp = (pf_we &&  pf_dir) ? pf_be : '0;
            assign vf_en_tv = (vf_we && !vf_dir) ? vf_be : '0;
            assign vf_en_tp = (vf_we &&  vf_dir) ? vf_be : '0;

            always_ff @(posedge clk) begin
                if (rst) begin
                    to_vf_q <= '0;
                    to_pf_q <= '0;
                end else begin
                    to_vf_q <= merge_word(to_vf_q, pf_en_tv, pf_wdata, vf_en_tv, vf_wdata);
                    to_pf_q <= merge_word(to_pf_q, pf_en_tp, pf_wdata, vf_en_tp, vf_wdata);
                end
            end

            assign pf_view      = pf_dir ? to_pf_q : to_vf_q;
            assign vf_view      = vf_dir ? to_pf_q : to_vf_q;
            assign p2v_half     = to_vf_q[HALF_W-1:0];
            assign v2p_half     = to_pf_q[HALF_W-1:0];
            assign upper_unused = to_vf_q[WORD_W-1:HALF_W] ^ to_pf_q[WORD_W-1:HALF_W];
        end else begin : g_shared
            logic [WORD_W-1:0] word_q;
            logic              dir_unused;

            always_ff @(posedge clk) begin
                if (rst)
                    word_q <= '0;
                else
                    word_q <= merge_word(word_q,
                                         pf_we ? pf_be : '0, pf_wdata,
                                         vf_we ? vf_be : '0, vf_wdata);
            end

            assign pf_view    = word_q;
            assign vf_view    = word_q;
            assign p2v_half   = word_q[HALF_W-1:0];
            assign v2p_half   = word_q[WORD_W-1:HALF_W];
            assign dir_unused = pf_dir ^ vf_dir;
        end
    endgenerate

endmodule

// File: rtl/mbx_pick.sv
module mbx_pick #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0] req,
    output logic [W-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i])
                idx = W'(i);
        end
    end

endmodule

// File: rtl/pfvf_mailbox.sv
module pfvf_mailbox
    import mbx_pkg::*;
#(
    parameter int  NUM_VF = 4,
    parameter bit  SPLIT  = 1'b0,
    localparam int IDX_W  = (NUM_VF > 1) ? $clog2(NUM_VF) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       pf_wr,
    input  logic [IDX_W-1:0]           pf_addr,
    input  logic [3:0]                 pf_be,
    input  logic [31:0]                pf_wdata,
    input  logic                       pf_dir,
    output logic [31:0]                pf_rdata,
    output logic                       pf_irq,
    output logic [NUM_VF-1:0]          pf_pending,
    output logic [IDX_W-1:0]           pf_src_idx,
    output logic                       pf_msg_sys,
    output logic [3:0]                 pf_msg_type,
    output logic [9:0]                 pf_msg_data,
    input  logic [NUM_VF-1:0]          vf_wr,
    input  logic [NUM_VF*IDX_W-1:0]    vf_addr,
    input  logic [NUM_VF*4-1:0]        vf_be,
    input  logic [NUM_VF*32-1:0]       vf_wdata,
    input  logic [NUM_VF-1:0]          vf_dir,
    output logic [NUM_VF*32-1:0]       vf_rdata,
    output logic [NUM_VF-1:0]          vf_deny,
    output logic [NUM_VF-1:0]          vf_irq,
    output logic [NUM_VF-1:0]          vf_msg_sys,
    output logic [NUM_VF*4-1:0]        vf_msg_type,
    output logic [NUM_VF*10-1:0]       vf_msg_data
);

    logic [WORD_W-1:0] pf_view_a  [NUM_VF];
    logic [HALF_W-1:0] p2v_half_a [NUM_VF];
    logic [HALF_W-1:0] v2p_half_a [NUM_VF];

    generate
        for (genvar i = 0; i < NUM_VF; i++) begin : g_vf
            logic              own_hit;
            logic              pf_hit;
            logic [WORD_W-1:0] vf_view;
            msg_t              vf_msg;

            assign own_hit = (vf_addr[i*IDX_W +: IDX_W] == IDX_W'(i));
            assign pf_hit  = pf_wr && (pf_addr == IDX_W'(i));

            mbx_slot #(.SPLIT(SPLIT)) u_slot (
                .clk      (clk),
                .rst      (rst),
                .pf_we    (pf_hit),
                .pf_be    (pf_be),
                .pf_wdata (pf_wdata),
                .pf_dir   (pf_dir),
                .vf_we    (vf_wr[i] && own_hit),
                .vf_be    (vf_be[i*4 +: 4]),
                .vf_wdata (vf_wdata[i*32 +: 32]),
                .vf_dir   (vf_dir[i]),
                .pf_view  (pf_view_a[i]),
                .vf_view  (vf_view),
                .p2v_half (p2v_half_a[i]),
                .v2p_half (v2p_half_a[i])
            );

            assign vf_msg                  = decode_half(p2v_half_a[i]);
            assign vf_deny[i]              = !own_hit;
            assign vf_rdata[i*32 +: 32]    = own_hit ? vf_view : '0;
            assign vf_irq[i]               = p2v_half_a[i][0];
            assign pf_pending[i]           = v2p_half_a[i][0];
            assign vf_msg_sys[i]           = vf_msg.sys;
            assign vf_msg_type[i*4 +: 4]   = vf_msg.kind;
            assign vf_msg_data[i*10 +: 10] = vf_msg.data;
        end
    endgenerate

    // Host read mux and decode of the guest-to-host half at pf_addr
    logic [HALF_W-1:0] pf_sel_half;
    msg_t              pf_msg;

    always_comb begin
        pf_rdata    = '0;
        pf_sel_half = '0;
        for (int i = 0; i < NUM_VF; i++) begin
            if (pf_addr == IDX_W'(i)) begin
                pf_rdata    = pf_view_a[i];
                pf_sel_half = v2p_half_a[i];
            end
        end
    end

    assign pf_msg      = decode_half(pf_sel_half);
    assign pf_msg_sys  = pf_msg.sys;
    assign pf_msg_type = pf_msg.kind;
    assign pf_msg_data = pf_msg.data;
    assign pf_irq      = |pf_pending;

    mbx_pick #(.N(NUM_VF), .W(IDX_W)) u_pick (
        .req (pf_pending),
        .idx (pf_src_idx)
    );

endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
    parameter int  NUM_VF = 4,
    parameter bit  SPLIT  = 1'b0,
    localparam int IDX_W  = (NUM_VF > 1) ? $clog2(NUM_VF) : 1
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    pf_wr,
    input logic [IDX_W-1:0]        pf_addr,
    input logic [3:0]              pf_be,
    input logic [31:0]             pf_wdata,
    input logic                    pf_dir,
    input logic                    pf_irq,
    input logic [NUM_VF-1:0]       pf_pending,
    input logic [IDX_W-1:0]        pf_src_idx,
    input logic [NUM_VF-1:0]       vf_wr,
    input logic [NUM_VF*IDX_W-1:0] vf_addr,
    input logic [NUM_VF*4-1:0]     vf_be,
    input logic [NUM_VF*32-1:0]    vf_wdata,
    input logic [NUM_VF-1:0]       vf_dir,
    input logic [NUM_VF*32-1:0]    vf_rdata,
    input logic [NUM_VF-1:0]       vf_deny,
    input logic [NUM_VF-1:0]       vf_irq,
    input logic [NUM_VF-1:0]       vf_msg_sys
);

    localparam int UP_BIT  = SPLIT ? 0 : 16;
    localparam int UP_LANE = UP_BIT / 8;

    logic pf_to_up;
    assign pf_to_up = SPLIT ? pf_dir : 1'b1;

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (vf_irq == '0 && !pf_irq && pf_pending == '0));

    p_pick_r10: assert property (@(posedge clk) disable iff (rst)
        pf_irq |-> pf_pending[pf_src_idx]);

    generate
        for (genvar i = 0; i < NUM_VF; i++) begin : g_a
            logic vf_own, vf_to_up;
            assign vf_own   = (vf_addr[i*IDX_W +: IDX_W] == IDX_W'(i));
            assign vf_to_up = SPLIT ? vf_dir[i] : 1'b1;

            p_down_bell_r2: assert property (@(posedge clk) disable iff (rst)
                (pf_wr && pf_addr == IDX_W'(i) && pf_be[0] && pf_wdata[0] && !(SPLIT && pf_dir))
                |=> vf_irq[i]);

            p_up_bell_r3: assert property (@(posedge clk) disable iff (rst)
                (vf_wr[i] && vf_own && vf_to_up && vf_be[i*4 + UP_LANE] && vf_wdata[i*32 + UP_BIT]
                 && !(pf_wr && pf_addr == IDX_W'(i) && pf_to_up && pf_be[UP_LANE]))
                |=> (pf_pending[i] && pf_irq));

            p_host_ack_r4: assert property (@(posedge clk) disable iff (rst)
                (pf_wr && pf_addr == IDX_W'(i) && pf_to_up && pf_be[UP_LANE] && !pf_wdata[UP_BIT])
                |=> !pf_pending[i]);

            p_isolate_r6: assert property (@(posedge clk) disable iff (rst)
                (vf_wr[i] && !vf_own && !pf_wr)
                |=> ($stable(vf_irq[i]) && $stable(pf_pending[i])));

            p_deny_read_r6: assert property (@(posedge clk) disable iff (rst)
                vf_deny[i] |-> (vf_rdata[i*32 +: 32] == 32'h0));

            p_sys_needs_bell_r5: assert property (@(posedge clk) disable iff (rst)
                vf_msg_sys[i] |-> vf_irq[i]);
        end
    endgenerate

endmodule

bind pfvf_mailbox mbx_chk #(.NUM_VF(NUM_VF), .SPLIT(SPLIT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pf_wr      (pf_wr),
    .pf_addr    (pf_addr),
    .pf_be      (pf_be),
    .pf_wdata   (pf_wdata),
    .pf_dir     (pf_dir),
    .pf_irq     (pf_irq),
    .pf_pending (pf_pending),
    .pf_src_idx (pf_src_idx),
    .vf_wr      (vf_wr),
    .vf_addr    (vf_addr),
    .vf_be      (vf_be),
    .vf_wdata   (vf_wdata),
    .vf_dir     (vf_dir),
    .vf_rdata   (vf_rdata),
    .vf_deny    (vf_deny),
    .vf_irq     (vf_irq),
    .vf_msg_sys (vf_msg_sys)
);

// File: tb/pfvf_mailbox_tb.sv
module pfvf_mailbox_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 4;
    localparam int IW = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            pf_wr = 1'b0;
    logic [IW-1:0]   pf_addr = '0;
    logic [3:0]      pf_be = '0;
    logic [31:0]     pf_wdata = '0;
    logic            pf_dir = 1'b0;
    logic [NV-1:0]   vf_wr = '0;
    logic [NV*IW-1:0] vf_addr = {2'd3, 2'd2, 2'd1, 2'd0};
    logic [NV*4-1:0] vf_be = '0;
    logic [NV*32-1:0] vf_wdata = '0;
    logic [NV-1:0]   vf_dir = '0;

    logic [31:0]      pf_rdata, s_pf_rdata;
    logic             pf_irq, s_pf_irq;
    logic [NV-1:0]    pf_pending, s_pf_pending;
    logic [IW-1:0]    pf_src_idx, s_pf_src_idx;
    logic             pf_msg_sys, s_pf_msg_sys;
    logic [3:0]       pf_msg_type, s_pf_msg_type;
    logic [9:0]       pf_msg_data, s_pf_msg_data;
    logic [NV*32-1:0] vf_rdata, s_vf_rdata;
    logic [NV-1:0]    vf_deny, s_vf_deny;
    logic [NV-1:0]    vf_irq, s_vf_irq;
    logic [NV-1:0]    vf_msg_sys, s_vf_msg_sys;
    logic [NV*4-1:0]  vf_msg_type, s_vf_msg_type;
    logic [NV*10-1:0] vf_msg_data, s_vf_msg_data;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfvf_mailbox #(.NUM_VF(NV), .SPLIT(1'b0)) u_dut (
        .clk(clk), .rst(rst),
        .pf_wr(pf_wr), .pf_addr(pf_addr), .pf_be(pf_be), .pf_wdata(pf_wdata), .pf_dir(pf_dir),
        .pf_rdata(pf_rdata), .pf_irq(pf_irq), .pf_pending(pf_pending), .pf_src_idx(pf_src_idx),
        .pf_msg_sys(pf_msg_sys), .pf_msg_type(pf_msg_type), .pf_msg_data(pf_msg_data),
        .vf_wr(vf_wr), .vf_addr(vf_addr), .vf_be(vf_be), .vf_wdata(vf_wdata), .vf_dir(vf_dir),
        .vf_rdata(vf_rdata), .vf_deny(vf_deny), .vf_irq(vf_irq),
        .vf_msg_sys(vf_msg_sys), .vf_msg_type(vf_msg_type), .vf_msg_data(vf_msg_data)
    );

    pfvf_mailbox #(.NUM_VF(NV), .SPLIT(1'b1)) u_split (
        .clk(clk), .rst(rst),
        .pf_wr(pf_wr), .pf_addr(pf_addr), .pf_be(pf_be), .pf_wdata(pf_wdata), .pf_dir(pf_dir),
        .pf_rdata(s_pf_rdata), .pf_irq(s_pf_irq), .pf_pending(s_pf_pending), .pf_src_idx(s_pf_src_idx),
        .pf_msg_sys(s_pf_msg_sys), .pf_msg_type(s_pf_msg_type), .pf_msg_data(s_pf_msg_data),
        .vf_wr(vf_wr), .vf_addr(vf_addr), .vf_be(vf_be), .vf_wdata(vf_wdata), .vf_dir(vf_dir),
        .vf_rdata(s_vf_rdata), .vf_deny(s_vf_deny), .vf_irq(s_vf_irq),
        .vf_msg_sys(s_vf_msg_sys), .vf_msg_type(s_vf_msg_type), .vf_msg_data(s_vf_msg_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pf_write(input int idx, input logic [3:0] be, input logic [31:0] d, input logic dir);
        @(negedge clk);
        pf_wr = 1'b1; pf_addr = IW'(idx); pf_be = be; pf_wdata = d; pf_dir = dir;
        @(negedge clk);
        pf_wr = 1'b0; pf_be = '0;
        #1;
    endtask

    task automatic vf_write(input int v, input int addr, input logic [3:0] be, input logic [31:0] d, input logic dir);
        @(negedge clk);
        vf_wr[v] = 1'b1; vf_addr[v*IW +: IW] = IW'(addr); vf_be[v*4 +: 4] = be;
        vf_wdata[v*32 +: 32] = d; vf_dir[v] = dir;
        @(negedge clk);
        vf_wr[v] = 1'b0; vf_be[v*4 +: 4] = '0; vf_addr[v*IW +: IW] = IW'(v);
        #1;
    endtask

    function automatic logic [31:0] vrd(input int v);
        return vf_rdata[v*32 +: 32];
    endfunction

    task automatic pf_peek(input int idx, input logic dir);
        pf_addr = IW'(idx); pf_dir = dir;
        #1;
    endtask

    task automatic t_reset();
        chk("R1 vf_irq after reset", 32'(vf_irq), 32'h0);
        chk("R1 pf_irq after reset", 32'(pf_irq), 32'h0);
        chk("R1 pending after reset", 32'(pf_pending), 32'h0);
        for (int i = 0; i < NV; i++) begin
            pf_peek(i, 1'b0);
            chk("R1 word zero after reset", pf_rdata, 32'h0);
        end
    endtask

    task automatic t_host_to_guest();
        // bell=1 origin=1 type=9 data=0x155
        pf_write(2, 4'b0011, 32'h0000_5567, 1'b0);
        chk("R2 vf_irq after host bell", 32'(vf_irq), 32'h4);
        chk("R5 guest sys flag", 32'(vf_msg_sys), 32'h4);
        chk("R5 guest type field", 32'(vf_msg_type[8 +: 4]), 32'h9);
        chk("R5 guest data field", 32'(vf_msg_data[20 +: 10]), 32'h155);
        chk("R7 guest reads own word", vrd(2), 32'h0000_5567);
        pf_peek(2, 1'b0);
        chk("R7 host reads word", pf_rdata, 32'h0000_5567);
    endtask

    task automatic t_guest_to_host();
        vf_write(2, 2, 4'b1100, 32'h0017_0000, 1'b0);
        chk("R3 pending after guest bell", 32'(pf_pending), 32'h4);
        chk("R3 pf_irq after guest bell", 32'(pf_irq), 32'h1);
        chk("R10 source index", 32'(pf_src_idx), 32'h2);
        pf_peek(2, 1'b0);
        chk("R8 low half kept on upper write", pf_rdata, 32'h0017_5567);
        chk("R5 host sys flag", 32'(pf_msg_sys), 32'h1);
        chk("R5 host type field", 32'(pf_msg_type), 32'h5);
        chk("R5 host data field", 32'(pf_msg_data), 32'h0);
    endtask

    task automatic t_legacy();
        vf_write(1, 1, 4'b1100, 32'h0001_0000, 1'b0);
        chk("R3 pending two guests", 32'(pf_pending), 32'h6);
        chk("R10 lowest pending wins", 32'(pf_src_idx), 32'h1);
        pf_peek(1, 1'b0);
        chk("R5 legacy origin not sys", 32'(pf_msg_sys), 32'h0);
    endtask

    task automatic t_ack();
        pf_write(1, 4'b0100, 32'h0, 1'b0);
        chk("R4 host ack guest1", 32'(pf_pending), 32'h4);
        chk("R10 source moves to 2", 32'(pf_src_idx), 32'h2);
        pf_write(2, 4'b0100, 32'h0, 1'b0);
        chk("R4 host ack guest2 pending", 32'(pf_pending), 32'h0);
        chk("R4 host ack irq low", 32'(pf_irq), 32'h0);
        vf_write(2, 2, 4'b0001, 32'h0, 1'b0);
        chk("R4 guest ack irq low", 32'(vf_irq), 32'h0);
        pf_peek(2, 1'b0);
        chk("R8 only enabled bytes changed", pf_rdata, 32'h0000_5500);
    endtask

    task automatic t_isolate();
        @(negedge clk);
        vf_addr[3*IW +: IW] = IW'(0);
        #1;
        chk("R6 deny on foreign index", 32'(vf_deny), 32'h8);
        chk("R6 foreign read is zero", vrd(3), 32'h0);
        vf_addr[3*IW +: IW] = IW'(3);
        vf_write(3, 0, 4'b1111, 32'hFFFF_FFFF, 1'b0);
        pf_peek(0, 1'b0);
        chk("R6 foreign write ignored", pf_rdata, 32'h0);
        chk("R6 no irq from foreign write", 32'(vf_irq), 32'h0);
        chk("R6 no pending from foreign write", 32'(pf_pending), 32'h0);
    endtask

    task automatic t_collide();
        @(negedge clk);
        pf_wr = 1'b1; pf_addr = IW'(0); pf_be = 4'b0001; pf_wdata = 32'h0000_0003; pf_dir = 1'b0;
        vf_wr[0] = 1'b1; vf_be[3:0] = 4'b0011; vf_wdata[31:0] = 32'h0000_AA00;
        @(negedge clk);
        pf_wr = 1'b0; pf_be = '0; vf_wr[0] = 1'b0; vf_be[3:0] = '0;
        #1;
        pf_peek(0, 1'b0);
        chk("R9 host wins shared byte", pf_rdata, 32'h0000_AA03);
        chk("R9 host bell stored", 32'(vf_irq), 32'h1);
    endtask

    task automatic t_split();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1;
        pf_write(1, 4'b0001, 32'h3, 1'b0);
        chk("R11 split down bell irq", 32'(s_vf_irq), 32'h2);
        chk("R11 split no pending yet", 32'(s_pf_pending), 32'h0);
        pf_write(1, 4'b0001, 32'h3, 1'b1);
        chk("R11 split up bell pending", 32'(s_pf_pending), 32'h2);
        pf_peek(1, 1'b1);
        chk("R11 split host reads up word", s_pf_rdata, 32'h3);
        chk("R11 split up word sys", 32'(s_pf_msg_sys), 32'h1);
        vf_write(1, 1, 4'b0001, 32'h0, 1'b0);
        chk("R11 split guest ack down", 32'(s_vf_irq), 32'h0);
        chk("R11 split up word untouched", 32'(s_pf_pending), 32'h2);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_host_to_guest();
        t_guest_to_host();
        t_legacy();
        t_ack();
        t_isolate();
        t_collide();
        t_split();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule